// File: doc/BRIEF.md
# Debug TAP Scan Chain Selector

This block sits behind the state machine of a JTAG debug port. It decodes the 5-bit instruction the port currently holds. It also keeps a small chain-select register that the host loads through the data path. From these two it routes the data-register path to one of several downstream scan chains, to an identification register, to a one-bit bypass register, or to the select register itself. The downstream chains are a status/control chain, an instruction-transfer chain, a data-transfer chain and a breakpoint chain. It gives each chain an enable and qualified capture, shift and update strobes. It also gives them a direction bit that tells a chain whether the current access reads or writes it.

The host selects a chain in two steps. First it loads the select instruction and shifts in a chain number, which takes effect at Update-DR. Then it switches to one of the two chain-access instructions. Each capture of the select register loads a fixed marker, so the host can confirm that the serial link works. A separate shortcut instruction reaches the instruction-transfer chain directly. It leaves the stored chain number alone, so the host can alternate between instruction and data transfers without reselecting.

Top module: `dbgtap_chain_router`

## Requirements
- R1: Instruction codes select the data path between tdi and tdo: 0x02 (select-load) picks the 5-bit select shift register, 0x1E picks the 32-bit identification register, and 0x1F, 0x08, 0x04 and every code not named in R1, R2 or R5 pick the 1-bit bypass register.
- R2: Under chain-read (0x0C) or chain-write (0x00), chainEn has exactly bit N set when the stored select value N is between 1 and NUM_CHAINS-1; for value 0 or out of range, chainEn is zero and the bypass register is used. chainEn never has more than one bit set.
- R3: A Capture-DR under 0x02 loads the select shift register with 5'b10000; shifted least-significant bit first, the host sees 0,0,0,0,1.
- R4: The stored select value (chainSel) changes only at an Update-DR under 0x02, taking the last five bits shifted in (first bit in becomes bit 0); shifting alone, or an Update-DR under any other instruction, leaves it unchanged.
- R5: Under 0x1D, chainEn selects chain 4 whatever the stored value is, and the stored value is not changed, even by an Update-DR.
- R6: chainCapture, chainShift and chainUpdate follow captureDr, shiftDr and updateDr while some chainEn bit is set, and are 0 otherwise.
- R7: chainWrite is 1 while a chain is enabled under 0x00 or 0x1D, and 0 under 0x0C or when no chain is enabled.
- R8: The bypass register captures 0, so the first bit out after capture is 0 and later bits repeat tdi one shift late.
- R9: The identification register captures ID_VALUE and shifts it out least-significant bit first.
- R10: trstN low, or tlrState high at a rising tck edge, sets the stored select value to 0.
- R11: While a chain is enabled, tdo equals that chain's bit of chainTdo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tlrState | input | 1 | Port state machine is in Test-Logic-Reset |
| captureDr | input | 1 | State machine is in Capture-DR |
| shiftDr | input | 1 | State machine is in Shift-DR |
| updateDr | input | 1 | State machine is in Update-DR |
| tdi | input | 1 | Serial data in |
| instr | input | 5 | Current instruction |
| chainTdo | input | NUM_CHAINS | Serial outputs of the downstream chains, one per chain number |
| tdo | output | 1 | Serial data out of the selected data path |
| chainEn | output | NUM_CHAINS | One-hot enable of the routed chain |
| chainCapture | output | 1 | Capture strobe for the enabled chain |
| chainShift | output | 1 | Shift strobe for the enabled chain |
| chainUpdate | output | 1 | Update strobe for the enabled chain |
| chainWrite | output | 1 | Access direction: 1 write, 0 read |
| chainSel | output | 5 | Stored chain number |

## Verification
The bench checks that an Update-DR under the shortcut instruction does not change the stored chain number. A design that wrote the number back would lose the data-transfer chain after each instruction transfer. It checks the capture marker bit by bit, which catches a reversed shift direction or a wrong pattern. Chain number 0 and out-of-range numbers must enable nothing, since an enable there would start stray chain activity. Random mixes of chain numbers and instructions check that strobes and direction appear only when a chain is routed.

// File: rtl/dbgtap_pkg.sv
package dbgtap_pkg;
  localparam int IR_W = 5;

  localparam logic [IR_W-1:0] OP_CHAIN_WR = 5'h00;
  localparam logic [IR_W-1:0] OP_SEL_LOAD = 5'h02;
  localparam logic [IR_W-1:0] OP_RESUME   = 5'h04;
  localparam logic [IR_W-1:0] OP_STOP     = 5'h08;
  localparam logic [IR_W-1:0] OP_CHAIN_RD = 5'h0C;
  localparam logic [IR_W-1:0] OP_ITR_PICK = 5'h1D;
  localparam logic [IR_W-1:0] OP_IDENT    = 5'h1E;
  localparam logic [IR_W-1:0] OP_BYP      = 5'h1F;

  typedef enum logic [1:0] {
    SRC_BYP   = 2'd0,
    SRC_SEL   = 2'd1,
    SRC_ID    = 2'd2,
    SRC_CHAIN = 2'd3
  } tdoSrc_e;

  typedef struct packed {
    logic    capSel;
    logic    shSel;
    logic    upSel;
    logic    capByp;
    logic    shByp;
    logic    capId;
    logic    shId;
    tdoSrc_e tdoSrc;
  } drStrobe_t;
endpackage

// File: rtl/dbgtap_ctrl.sv
module dbgtap_ctrl
  import dbgtap_pkg::*;
#(
  parameter int SEL_W      = 5,
  parameter int NUM_CHAINS = 8,
  parameter int ITR_CHAIN  = 4
) (
  input  logic                  tck,
  input  logic                  trstN,
  input  logic [IR_W-1:0]       instr,
  input  logic                  captureDr,
  input  logic                  shiftDr,
  input  logic                  updateDr,
  input  logic [SEL_W-1:0]      selReg,
  output drStrobe_t             st,
  output logic [NUM_CHAINS-1:0] chainEn,
  output logic                  chainCapture,
  output logic                  chainShift,
  output logic                  chainUpdate,
  output logic                  chainWrite
);
  logic isSelLoad, isIdent, isItr, isChainAcc, isWrite, anyEn;

  always_comb begin
    isSelLoad  = (instr == OP_SEL_LOAD);
    isIdent    = (instr == OP_IDENT);
    isItr      = (instr == OP_ITR_PICK);
    isChainAcc = (instr == OP_CHAIN_RD) || (instr == OP_CHAIN_WR);
    isWrite    = (instr == OP_CHAIN_WR) || isItr;
  end

  // One enable per chain number; chain 0 means no chain.
  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_en
    if (g == 0) begin : g_none
      assign chainEn[g] = 1'b0;
    end else begin : g_chain
      assign chainEn[g] = (isItr && (g == ITR_CHAIN)) ||
                          (isChainAcc && !isItr && (int'(selReg) == g));
    end
  end

  assign anyEn = |chainEn;

  always_comb begin
    if (isSelLoad)      st.tdoSrc = SRC_SEL;
    else if (isIdent)   st.tdoSrc = SRC_ID;
    else if (anyEn)     st.tdoSrc = SRC_CHAIN;
    else                st.tdoSrc = SRC_BYP;
    st.capSel = captureDr && isSelLoad;
    st.shSel  = shiftDr   && isSelLoad;
    st.upSel  = updateDr  && isSelLoad;
    st.capId  = captureDr && isIdent;
    st.shId   = shiftDr   && isIdent;
    st.capByp = captureDr && (st.tdoSrc == SRC_BYP);
    st.shByp  = shiftDr   && (st.tdoSrc == SRC_BYP);
  end

  assign chainCapture = anyEn && captureDr;
  assign chainShift   = anyEn && shiftDr;
  assign chainUpdate  = anyEn && updateDr;
  assign chainWrite   = anyEn && isWrite;

  // R2: never more than one chain routed
  a_r2_onehot_en: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0(chainEn));

  // R5: the shortcut always reaches the instruction-transfer chain
  a_r5_itr_route: assert property (@(posedge tck) disable iff (!trstN)
    (instr == OP_ITR_PICK) |-> (chainEn[ITR_CHAIN] && $countones(chainEn) == 1));

  // R6: no chain strobe without a routed chain
  a_r6_strobe_gated: assert property (@(posedge tck) disable iff (!trstN)
    (chainCapture || chainShift || chainUpdate || chainWrite) |-> (chainEn != '0));
endmodule

// File: rtl/dbgtap_dpath.sv
module dbgtap_dpath
  import dbgtap_pkg::*;
#(
  parameter int              SEL_W      = 5,
  parameter int              ID_W       = 32,
  parameter logic [ID_W-1:0] ID_VALUE   = 32'h4A5C_0E27,
  parameter int              NUM_CHAINS = 8
) (
  input  logic                  tck,
  input  logic                  trstN,
  input  logic                  tlrState,
  input  logic                  tdi,
  input  drStrobe_t             st,
  input  logic [NUM_CHAINS-1:0] chainEn,
  input  logic [NUM_CHAINS-1:0] chainTdo,
  output logic [SEL_W-1:0]      selReg,
  output logic                  tdo
);
  localparam logic [SEL_W-1:0] CAPT_MARK = {1'b1, {(SEL_W-1){1'b0}}};

  logic [SEL_W-1:0] selShift;
  logic [ID_W-1:0]  idShift;
  logic             bypassReg;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      selShift  <= '0;
      selReg    <= '0;
      idShift   <= '0;
      bypassReg <= 1'b0;
    end else begin
      if (st.capSel)      selShift <= CAPT_MARK;
      else if (st.shSel)  selShift <= {tdi, selShift[SEL_W-1:1]};

      if (tlrState)       selReg <= '0;
      else if (st.upSel)  selReg <= selShift;

      if (st.capId)       idShift <= ID_VALUE;
      else if (st.shId)   idShift <= {tdi, idShift[ID_W-1:1]};

      if (st.capByp)      bypassReg <= 1'b0;
      else if (st.shByp)  bypassReg <= tdi;
    end
  end

  always_comb begin
    case (st.tdoSrc)
      SRC_SEL:   tdo = selShift[0];
      SRC_ID:    tdo = idShift[0];
      SRC_CHAIN: tdo = |(chainTdo & chainEn);
      default:   tdo = bypassReg;
    endcase
  end

  // R4 / R10: stored chain number moves only on a select update or reset state
  a_r4_sel_hold: assert property (@(posedge tck) disable iff (!trstN)
    !$stable(selReg) |-> $past(st.upSel || tlrState));

  // R3: capture marker lands in the select shift register
  a_r3_capture_mark: assert property (@(posedge tck) disable iff (!trstN)
    st.capSel |=> (selShift == CAPT_MARK));

  // R8: bypass register captures zero
  a_r8_bypass_zero: assert property (@(posedge tck) disable iff (!trstN)
    st.capByp |=> (bypassReg == 1'b0));
endmodule

// File: rtl/dbgtap_chain_router.sv
module dbgtap_chain_router
  import dbgtap_pkg::*;
#(
  parameter int          NUM_CHAINS = 8,
  parameter int          ITR_CHAIN  = 4,
  parameter logic [31:0] ID_VALUE   = 32'h4A5C_0E27
) (
  input  logic                  tck,
  input  logic                  trstN,
  input  logic                  tlrState,
  input  logic                  captureDr,
  input  logic                  shiftDr,
  input  logic                  updateDr,
  input  logic                  tdi,
  input  logic [4:0]            instr,
  input  logic [NUM_CHAINS-1:0] chainTdo,
  output logic                  tdo,
  output logic [NUM_CHAINS-1:0] chainEn,
  output logic                  chainCapture,
  output logic                  chainShift,
  output logic                  chainUpdate,
  output logic                  chainWrite,
  output logic [4:0]            chainSel
);
  localparam int SEL_W = 5;
  localparam int ID_W  = 32;

  drStrobe_t st;
  logic [SEL_W-1:0] selReg;

  dbgtap_ctrl #(
    .SEL_W(SEL_W), .NUM_CHAINS(NUM_CHAINS), .ITR_CHAIN(ITR_CHAIN)
  ) ctrl_i (
    .tck(tck), .trstN(trstN), .instr(instr),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .selReg(selReg), .st(st), .chainEn(chainEn),
    .chainCapture(chainCapture), .chainShift(chainShift),
    .chainUpdate(chainUpdate), .chainWrite(chainWrite)
  );

  dbgtap_dpath #(
    .SEL_W(SEL_W), .ID_W(ID_W), .ID_VALUE(ID_VALUE), .NUM_CHAINS(NUM_CHAINS)
  ) dpath_i (
    .tck(tck), .trstN(trstN), .tlrState(tlrState), .tdi(tdi),
    .st(st), .chainEn(chainEn), .chainTdo(chainTdo),
    .selReg(selReg), .tdo(tdo)
  );

  assign chainSel = selReg;
endmodule

// File: tb/dbgtap_chain_router_tb_top.sv
module dbgtap_chain_router_tb_top;
  localparam int          NCH  = 8;
  localparam logic [31:0] IDV  = 32'h4A5C_0E27;

  logic tck = 1'b0;
  logic trstN, tlrState, captureDr, shiftDr, updateDr, tdi;
  logic [4:0] instr;
  logic [NCH-1:0] chainTdo;
  logic tdo, chainCapture, chainShift, chainUpdate, chainWrite;
  logic [NCH-1:0] chainEn;
  logic [4:0] chainSel;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 tck = ~tck;

  dbgtap_chain_router #(.NUM_CHAINS(NCH), .ITR_CHAIN(4), .ID_VALUE(IDV)) dut_i (
    .tck(tck), .trstN(trstN), .tlrState(tlrState), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .instr(instr),
    .chainTdo(chainTdo), .tdo(tdo), .chainEn(chainEn),
    .chainCapture(chainCapture), .chainShift(chainShift),
    .chainUpdate(chainUpdate), .chainWrite(chainWrite), .chainSel(chainSel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] expEn(input logic [4:0] op, input logic [4:0] sel);
    logic [NCH-1:0] v = '0;
    if (op == 5'h1D) v[4] = 1'b1;
    else if ((op == 5'h00 || op == 5'h0C) && sel != 0 && int'(sel) < NCH) v[sel] = 1'b1;
    return v;
  endfunction

  function automatic logic expWr(input logic [4:0] op, input logic [4:0] sel);
    return (expEn(op, sel) != '0) && (op == 5'h00 || op == 5'h1D);
  endfunction

  task automatic scan(input logic [31:0] din, input int n, output logic [31:0] dout);
    dout = '0;
    captureDr = 1'b1; @(negedge tck); captureDr = 1'b0;
    for (int i = 0; i < n; i++) begin
      shiftDr = 1'b1; tdi = din[i]; #1;
      dout[i] = tdo;
      @(negedge tck);
    end
    shiftDr = 1'b0; updateDr = 1'b1; @(negedge tck); updateDr = 1'b0;
  endtask

  task automatic loadSel(input logic [4:0] v, output logic [31:0] dout);
    instr = 5'h02;
    scan({27'd0, v}, 5, dout);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [4:0] ops [8];
    ops = '{5'h00, 5'h02, 5'h04, 5'h08, 5'h0C, 5'h1D, 5'h1E, 5'h1F};
    void'($urandom(32'd2024));
    trstN = 0; tlrState = 0; captureDr = 0; shiftDr = 0; updateDr = 0;
    tdi = 0; instr = 5'h1E; chainTdo = '0;
    repeat (3) @(negedge tck);
    trstN = 1; @(negedge tck);

    // R10 reset state
    check("R10 reset sel", chainSel, 0);
    instr = 5'h0C; #1;
    check("R2 chain0 no enable", chainEn, 0);

    // R9 identification
    instr = 5'h1E;
    scan(32'h0, 32, d);
    check("R9 idcode", d, IDV);

    // R3 capture marker, R4 update
    loadSel(5'd5, d);
    check("R3 capture mark", d[4:0], 5'b10000);
    check("R4 sel updated", chainSel, 5);

    // R4 shifting without update under select-load
    captureDr = 1; @(negedge tck); captureDr = 0;
    for (int i = 0; i < 5; i++) begin shiftDr = 1; tdi = 1; @(negedge tck); end
    shiftDr = 0; #1;
    check("R4 shift no update", chainSel, 5);

    // R5 shortcut leaves select alone, even on update
    instr = 5'h1D; chainTdo = 8'b0001_0000; #1;
    check("R5 itr en", chainEn, 8'h10);
    check("R11 itr tdo", tdo, 1);
    check("R7 itr write", chainWrite, 1);
    scan(32'hFFFF_FFFF, 5, d);
    check("R5 sel kept", chainSel, 5);
    instr = 5'h0C; #1;
    check("R2 back to chain5", chainEn, 8'h20);
    check("R7 read dir", chainWrite, 0);

    // R8 bypass
    instr = 5'h1F;
    scan(32'b1011, 4, d);
    check("R8 bypass", d[3:0], 4'b0110);
    check("R4 update other op", chainSel, 5);

    // R2 out of range
    loadSel(5'd20, d);
    instr = 5'h00; chainTdo = '1; tdi = 0; #1;
    check("R2 out of range", chainEn, 0);
    captureDr = 1; #1;
    check("R6 no strobe", chainCapture, 0);
    @(negedge tck); captureDr = 0;

    // R10 test-logic-reset clears
    tlrState = 1; @(negedge tck); tlrState = 0; #1;
    check("R10 tlr clear", chainSel, 0);

    // random mix
    for (int it = 0; it < 200; it++) begin
      logic [4:0] s, op;
      logic [NCH-1:0] e;
      s = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 3) == 0) s = 5'($urandom_range(0, 7));
      loadSel(s, d);
      check("R3 mark random", d[4:0], 5'b10000);
      check("R4 sel random", chainSel, 32'(s));
      op = ops[$urandom_range(0, 7)];
      if ($urandom_range(0, 7) == 0) op = 5'($urandom_range(0, 31));
      instr = op; chainTdo = NCH'($urandom); #1;
      e = expEn(op, s);
      check("R2 R5 enable", chainEn, 32'(e));
      check("R7 direction", chainWrite, 32'(expWr(op, s)));
      if (e != '0) check("R11 tdo route", tdo, 32'(|(chainTdo & e)));
      shiftDr = 1; #0.5;
      check("R6 shift strobe", chainShift, 32'(e != '0));
      @(negedge tck); shiftDr = 0;
      updateDr = 1; #0.5;
      check("R6 update strobe", chainUpdate, 32'(e != '0));
      @(negedge tck); updateDr = 0;
      if (op != 5'h02) check("R4 no side update", chainSel, 32'(s));
      if (op == 5'h1F || op == 5'h04 || op == 5'h08) begin
        scan(32'b01, 2, d);
        check("R1 R8 bypass path", d[1:0], 2'b10);
      end
    end

    done = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule